// File: doc/BRIEF.md
# Grouped Four-Output Interrupt Controller

This block collects sixteen external interrupt request lines and presents them to a processor as four interrupt outputs. Each request line passes through a two-flop synchroniser and is then sensed: lines 0 through 14 are active-low and level-sensitive, and line 15 is sensed on its falling edge, for a button-style non-maskable source. A sensed request sets a bit in a 16-bit pending register. A 16-bit enable-blocking register, where a 1 blocks the line, gates the pending bits. Each of the four outputs is the OR of the unblocked pending bits that belong to its fixed group of lines. The groups do not overlap.

Software reaches both registers through a plain strobe port. A write takes effect in one cycle. A read returns its data one cycle after the strobe. The request lines and the register port carry no stream data, so they have no valid/ready handshake and no back-pressure: a strobe is always accepted in the cycle it is presented. A driver normally blocks lines 1 to 14 at start-up by writing 0x7FFE. It then enables lines one by one. It services an output by reading the pending register and writing 0 to the bits it has handled.

Top module: `irqc_top`

## Requirements
- R1: After reset the block register reads 0xFFFF, the pending register reads 0x0000, and all four outputs are low.
- R2: A write with address 0 loads the block register. A read strobe returns the block register (address 0) or the pending register (address 1) on the read data bus in the cycle after the strobe.
- R3: Lines 0 to 14 are active-low and level-sensitive. A line held low sets its pending bit within three clock edges of the change on the pin.
- R4: Line 15 sets pending bit 15 only on a high-to-low transition. Holding it low after a clear does not set the bit again, and a rising transition sets nothing.
- R5: A write with address 1 clears each pending bit whose data bit is 0 and leaves each bit whose data bit is 1 unchanged. Writing 0xFFFF clears nothing.
- R6: While a level-sensitive line stays low, clearing its pending bit has no effect.
- R7: Block bit 1 stops its line from driving any output, but the pending bit still latches and reads back.
- R8: Output k is high exactly when some line of its group has a pending bit set and its block bit clear. The groups are: output 0 lines {3,5} (0x0028), output 1 lines {4,6} (0x0050), output 2 lines {10,11,12} (0x1C00), output 3 lines {1,2,7,8,9,13,14} (0x6386).
- R9: Lines 0 and 15 belong to no group. Their pending bits latch and read back but never raise an output.
- R10: Writing the block register does not change the pending register, and the block register changes only on a write with address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n_in | input | 16 | Asynchronous request lines, active low |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 1 | Register select: 0 block, 1 pending |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_out | output | 4 | Grouped interrupt outputs, active high |

## Verification
The checker covers the following on every clock: block-register loading and stability, the clear-by-zero and keep-by-one rules of a pending write, and the rule that a sensed request always lands in its pending bit. It also checks that line 15's set pulse lasts a single cycle, that read data follows the selected register, and that the outputs stay low when nothing is pending or everything is blocked. The bench scenarios cover the rest, which depends on pin-level sequences over many cycles. These are the group routing of each output, the stickiness of a held-low level line against clears, edge-only sensing of line 15 across hold, release and re-press, and the reset values read through the port.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int IRQC_LINES = 16;
  localparam int IRQC_OUTS  = 4;

  typedef enum logic {
    SEL_BLOCK   = 1'b0,
    SEL_PENDING = 1'b1
  } irqc_sel_e;

  // group k occupies bits [k*16 +: 16]
  localparam logic [IRQC_OUTS*IRQC_LINES-1:0] IRQC_GROUPS =
    {16'h6386, 16'h1C00, 16'h0050, 16'h0028};

  // 1 = falling-edge sensed, 0 = active-low level
  localparam logic [IRQC_LINES-1:0] IRQC_EDGE_SEL = 16'h8000;

  localparam logic [IRQC_LINES-1:0] IRQC_BLOCK_RST = '1;
endpackage

// File: rtl/irqc_sync.sv
`timescale 1ns/1ps
module irqc_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_n,
  output logic [W-1:0] sync_n
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '1;
        else        chain[s] <= async_n;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '1;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/irqc_sense.sv
`timescale 1ns/1ps
module irqc_sense #(
  parameter int           W        = 16,
  parameter logic [W-1:0] EDGE_SEL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_n,
  output logic [W-1:0] set_vec
);
  logic [W-1:0] prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n <= '1;
    else        prev_n <= sync_n;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    if (EDGE_SEL[i]) begin : g_edge
      assign set_vec[i] = prev_n[i] & ~sync_n[i];
    end else begin : g_level
      assign set_vec[i] = ~sync_n[i];
    end
  end
endmodule

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  irqc_sel_e    sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] block_q,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] rdata
);
  logic wr_block, wr_pend;
  logic [W-1:0] pend_keep;

  assign wr_block  = wr_en && (sel == SEL_BLOCK);
  assign wr_pend   = wr_en && (sel == SEL_PENDING);
  assign pend_keep = wr_pend ? (pend_q & wdata) : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        block_q <= IRQC_BLOCK_RST[W-1:0];
    else if (wr_block) block_q <= wdata;
  end

  // a new request in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_keep | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= (sel == SEL_BLOCK) ? block_q : pend_q;
  end
endmodule

// File: rtl/irqc_route.sv
`timescale 1ns/1ps
module irqc_route #(
  parameter int                   W      = 16,
  parameter int                   N_OUT  = 4,
  parameter logic [N_OUT*W-1:0]   GROUPS = '0
) (
  input  logic [W-1:0]     pend_q,
  input  logic [W-1:0]     block_q,
  output logic [N_OUT-1:0] irq_out
);
  logic [W-1:0] live;
  assign live = pend_q & ~block_q;

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign irq_out[k] = |(GROUPS[k*W +: W] & live);
  end
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
  import irqc_pkg::*;
#(
  parameter int                      N_IN        = IRQC_LINES,
  parameter int                      N_OUT       = IRQC_OUTS,
  parameter int                      SYNC_STAGES = 2,
  parameter logic [N_OUT*N_IN-1:0]   GROUPS      = IRQC_GROUPS,
  parameter logic [N_IN-1:0]         EDGE_SEL    = IRQC_EDGE_SEL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  irq_n_in,
  input  logic             bus_wr_en,
  input  logic             bus_rd_en,
  input  logic             bus_addr,
  input  logic [N_IN-1:0]  bus_wdata,
  output logic [N_IN-1:0]  bus_rdata,
  output logic [N_OUT-1:0] irq_out
);
  logic [N_IN-1:0] sync_n;
  logic [N_IN-1:0] set_vec;
  logic [N_IN-1:0] block_q;
  logic [N_IN-1:0] pend_q;
  irqc_sel_e       sel;

  assign sel = irqc_sel_e'(bus_addr);

  irqc_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_n(irq_n_in), .sync_n(sync_n)
  );

  irqc_sense #(.W(N_IN), .EDGE_SEL(EDGE_SEL)) u_sense (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .set_vec(set_vec)
  );

  irqc_regs #(.W(N_IN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .sel(sel), .wdata(bus_wdata), .set_vec(set_vec),
    .block_q(block_q), .pend_q(pend_q), .rdata(bus_rdata)
  );

  irqc_route #(.W(N_IN), .N_OUT(N_OUT), .GROUPS(GROUPS)) u_route (
    .pend_q(pend_q), .block_q(block_q), .irq_out(irq_out)
  );
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker #(
  parameter int W     = 16,
  parameter int N_OUT = 4,
  parameter int EDGE  = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr_en,
  input logic             bus_rd_en,
  input logic             bus_addr,
  input logic [W-1:0]     bus_wdata,
  input logic [W-1:0]     bus_rdata,
  input logic [N_OUT-1:0] irq_out,
  input logic [W-1:0]     block_q,
  input logic [W-1:0]     pend_q,
  input logic [W-1:0]     set_vec
);
  assert_block_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && !bus_addr) |=> block_q == $past(bus_wdata));

  assert_block_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && !bus_addr) |=> $stable(block_q));

  assert_read_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !bus_addr) |=> bus_rdata == $past(block_q));

  assert_read_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr) |=> bus_rdata == $past(pend_q));

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr) |=> (pend_q & ~$past(bus_wdata) & ~$past(set_vec)) == '0);

  assert_keep_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr) |=> ($past(pend_q) & $past(bus_wdata) & ~pend_q) == '0);

  assert_request_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q & $past(set_vec)) == $past(set_vec));

  assert_edge_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[EDGE] |=> !set_vec[EDGE]);

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (irq_out == '0));

  assert_all_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&block_q) |-> (irq_out == '0));
endmodule

bind irqc_top irqc_checker #(.W(N_IN), .N_OUT(N_OUT), .EDGE(N_IN-1)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .block_q(block_q), .pend_q(pend_q), .set_vec(set_vec)
);

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_n = 16'hFFFF;
  logic        wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic [3:0]  irq_out;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_cap = 1'b0;
  logic [15:0] e_val;
  string       e_tag;

  always #5 clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .irq_n_in(irq_n), .bus_wr_en(wr_en),
    .bus_rd_en(rd_en), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_out(irq_out)
  );

  // monitor: a strobe seen at a rising edge yields data checked at the next falling edge
  always @(posedge clk) rd_cap <= rd_en;
  always @(negedge clk) begin
    if (rd_cap) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2: read data %h with no expected item", rdata);
      end else begin
        e_val = exp_q.pop_front();
        e_tag = tag_q.pop_front();
        if (rdata !== e_val) begin
          n_bad++;
          $display("FAIL %s: rdata=%h expected %h", e_tag, rdata, e_val);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [15:0] exp_v, input string tag);
    exp_q.push_back(exp_v); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pins(input logic [15:0] v);
    @(negedge clk); irq_n = v;
    idle(4);
  endtask

  task automatic chk_out(input logic [3:0] exp_v, input string tag);
    n_cmp++;
    if (irq_out !== exp_v) begin
      n_bad++;
      $display("FAIL %s: irq_out=%b expected %b", tag, irq_out, exp_v);
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    chk_out(4'b0000, "R1 outputs in reset");
    rst_n = 1'b1;
    idle(2);
    chk_out(4'b0000, "R1 outputs after reset");
    rd(1'b0, 16'hFFFF, "R1 block reset");
    rd(1'b1, 16'h0000, "R1 pending reset");

    wr(1'b0, 16'h7FFE);
    rd(1'b0, 16'h7FFE, "R2 block write");

    // R3/R7: line 3 low while blocked
    pins(16'hFFF7);
    rd(1'b1, 16'h0008, "R3 level line latched");
    chk_out(4'b0000, "R7 blocked line silent");
    wr(1'b0, 16'h0000);
    idle(1);
    chk_out(4'b0001, "R8 group 0 asserted");

    // R6: clear while held low
    wr(1'b1, 16'hFFF7);
    idle(1);
    rd(1'b1, 16'h0008, "R6 held line survives clear");
    pins(16'hFFFF);
    wr(1'b1, 16'hFFFF);
    rd(1'b1, 16'h0008, "R5 all-ones write clears nothing");
    wr(1'b1, 16'hFFF7);
    rd(1'b1, 16'h0000, "R5 zero bit clears");
    chk_out(4'b0000, "R5 output drops after clear");

    // R8 each group alone
    pins(16'hFFDF); chk_out(4'b0001, "R8 line 5 to output 0");
    pins(16'hFFFF); wr(1'b1, 16'h0000);
    pins(16'hFFBF); chk_out(4'b0010, "R8 line 6 to output 1");
    pins(16'hFFFF); wr(1'b1, 16'h0000);
    pins(16'hEFFF); chk_out(4'b0100, "R8 line 12 to output 2");
    pins(16'hFFFF); wr(1'b1, 16'h0000);
    pins(16'hFEFF); chk_out(4'b1000, "R8 line 8 to output 3");
    pins(16'hFFFF); wr(1'b1, 16'h0000);
    idle(1);
    chk_out(4'b0000, "R8 all cleared");

    // R8/R7/R10: several lines
    pins(16'hDBEF);
    chk_out(4'b1110, "R8 lines 4,10,13");
    wr(1'b0, 16'h0410);
    idle(1);
    chk_out(4'b1000, "R7 lines 4,10 blocked");
    rd(1'b1, 16'h2410, "R10 block write keeps pending");
    pins(16'hFFFF);
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h0000);
    rd(1'b1, 16'h0000, "R5 clear all");

    // R4/R9: edge line 15
    pins(16'h7FFF);
    rd(1'b1, 16'h8000, "R4 falling edge latched");
    chk_out(4'b0000, "R9 line 15 in no group");
    wr(1'b1, 16'h7FFF);
    idle(3);
    rd(1'b1, 16'h0000, "R4 held low does not re-set");
    pins(16'hFFFF);
    rd(1'b1, 16'h0000, "R4 rising edge sets nothing");
    pins(16'h7FFF);
    rd(1'b1, 16'h8000, "R4 second press latched");
    pins(16'hFFFF);
    wr(1'b1, 16'h0000);

    // R9: line 0
    pins(16'hFFFE);
    rd(1'b1, 16'h0001, "R9 line 0 latched");
    chk_out(4'b0000, "R9 line 0 in no group");
    pins(16'hFFFF);
    wr(1'b1, 16'h0000);
    rd(1'b1, 16'h0000, "R5 final clear");

    idle(2);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: %0d reads unanswered, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule